// File: doc/BRIEF.md
# Segment Base Access Unit

This block keeps the two 64-bit segment base registers (the FS-side and GS-side bases) and carries out the four instructions that read or write them directly. Each request gives a two-bit operation code, an operand-size flag, a 64-bit source value and the current execution mode. Either the read result comes back one cycle later with a valid strobe, or a one-cycle invalid-opcode fault strobe comes back in its place. Both bases are also driven out at all times for address generation.

An enable bit gates the four operations. It sits in a control register bit that this block holds and that is written through a small control port; the bit clears on reset. The operations are legal only while that bit is set and the core runs in 64-bit sub-mode. Privilege level plays no part in the check. A separate privileged load port lets context-switch code restore either base with a full 64-bit value. This port is never gated and wins over an instruction write to the same base in the same cycle.

Top module: `seg_base_unit`

## Requirements
- R1: While reset is high and in the cycle after it, both bases are zero and the enable bit is clear. The read-valid, read-data and fault outputs are also zero.
- R2: When the enable bit is clear, any requested operation gives a fault strobe in the following cycle, no read-valid, and no change to either base.
- R3: Execution mode is coded as 00 real, 01 compatibility, 10 64-bit, 11 protected. Only mode 10 allows the operations. Any other mode faults, with no read-valid and no base change.
- R4: Operation codes are 00 read FS, 01 read GS, 10 write FS, 11 write GS. With the wide flag set, a legal read returns all 64 bits of the chosen base, with read-valid high in the next cycle.
- R5: With the wide flag clear, a legal read returns the low 32 bits of the base and forces bits 63..32 of the result to zero.
- R6: With the wide flag set, a legal write loads all 64 source bits into the chosen base, visible one cycle later. A write gives no read-valid.
- R7: With the wide flag clear, a legal write loads the low 32 source bits and clears bits 63..32 of the base.
- R8: The fault output is high for exactly one cycle per faulting request. It is never high together with read-valid.
- R9: The context load port (select 0 FS, 1 GS) writes all 64 bits with no gating. It overrides an instruction write to the same base in the same cycle, while an instruction write to the other base still takes effect.
- R10: A control write sets the enable bit from the following cycle on. A request in the same cycle as the control write is judged on the old enable value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Request present this cycle |
| op_code | input | 2 | Operation: 00 rd FS, 01 rd GS, 10 wr FS, 11 wr GS |
| op_wide | input | 1 | 1 = 64-bit operand, 0 = 32-bit operand |
| op_src | input | XLEN | Source value for writes |
| exec_mode | input | 2 | Current execution mode, 10 = 64-bit sub-mode |
| cr_we | input | 1 | Control register bit write strobe |
| cr_en | input | 1 | New value of the enable bit |
| ctx_we | input | 1 | Context-switch load strobe |
| ctx_sel | input | 1 | Context load target: 0 FS, 1 GS |
| ctx_data | input | XLEN | Context load value |
| rd_valid | output | 1 | Read result valid |
| rd_data | output | XLEN | Read result |
| fault_ud | output | 1 | Invalid-opcode fault strobe |
| fs_base | output | XLEN | Current FS base |
| gs_base | output | XLEN | Current GS base |

## Verification
The bench builds the unit with its default widths, XLEN 64 and NARROW 32. With these widths the upper half of each register can hold distinct nonzero patterns, so a narrow read or write that fails to clear bits 63..32 shows up directly at the ports. The same widths let one table pass through every operation code, both operand sizes and each of the four modes. Directed steps then cover the disabled state, the enable write landing in the same cycle as a request, and context loads colliding with instruction writes.

// File: rtl/sbu_pkg.sv
`timescale 1ns/1ps
package sbu_pkg;
  typedef enum logic [1:0] {
    SBU_RD_FS = 2'b00,
    SBU_RD_GS = 2'b01,
    SBU_WR_FS = 2'b10,
    SBU_WR_GS = 2'b11
  } sbu_op_e;

  localparam logic [1:0] SBU_MODE_LONG64 = 2'b10;

  function automatic logic sbu_is_write(input sbu_op_e op);
    return (op == SBU_WR_FS) || (op == SBU_WR_GS);
  endfunction

  function automatic logic sbu_target(input sbu_op_e op);
    return (op == SBU_RD_GS) || (op == SBU_WR_GS);
  endfunction
endpackage

// File: rtl/sbu_access_gate.sv
`timescale 1ns/1ps
module sbu_access_gate
  import sbu_pkg::*;
(
  input  logic       req,
  input  logic       en,
  input  logic [1:0] mode,
  output logic       grant,
  output logic       deny
);
  logic allowed;
  always_comb begin
    allowed = en && (mode == SBU_MODE_LONG64);
    grant   = req && allowed;
    deny    = req && !allowed;
  end
endmodule

// File: rtl/sbu_width_fmt.sv
`timescale 1ns/1ps
module sbu_width_fmt #(
  parameter int XLEN   = 64,
  parameter int NARROW = 32
) (
  input  logic [XLEN-1:0] din,
  input  logic            wide,
  output logic [XLEN-1:0] dout
);
  localparam int HI = XLEN - NARROW;
  always_comb begin
    if (wide) dout = din;
    else      dout = {{HI{1'b0}}, din[NARROW-1:0]};
  end
endmodule

// File: rtl/sbu_base_bank.sv
`timescale 1ns/1ps
module sbu_base_bank #(
  parameter int XLEN      = 64,
  parameter int NUM_BASES = 2,
  localparam int IDXW     = (NUM_BASES > 1) ? $clog2(NUM_BASES) : 1
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      ins_we,
  input  logic [IDXW-1:0]           ins_idx,
  input  logic [XLEN-1:0]           ins_data,
  input  logic                      ctx_we,
  input  logic [IDXW-1:0]           ctx_idx,
  input  logic [XLEN-1:0]           ctx_data,
  output logic [NUM_BASES*XLEN-1:0] bases_flat
);
  for (genvar g = 0; g < NUM_BASES; g++) begin : g_base
    logic [XLEN-1:0] base_q;
    always_ff @(posedge clk) begin
      if (rst)                                 base_q <= '0;
      else if (ctx_we && ctx_idx == IDXW'(g))  base_q <= ctx_data;
      else if (ins_we && ins_idx == IDXW'(g))  base_q <= ins_data;
    end
    assign bases_flat[g*XLEN +: XLEN] = base_q;
  end
endmodule

// File: rtl/seg_base_unit.sv
`timescale 1ns/1ps
module seg_base_unit
  import sbu_pkg::*;
#(
  parameter int XLEN   = 64,
  parameter int NARROW = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            op_valid,
  input  logic [1:0]      op_code,
  input  logic            op_wide,
  input  logic [XLEN-1:0] op_src,
  input  logic [1:0]      exec_mode,
  input  logic            cr_we,
  input  logic            cr_en,
  input  logic            ctx_we,
  input  logic            ctx_sel,
  input  logic [XLEN-1:0] ctx_data,
  output logic            rd_valid,
  output logic [XLEN-1:0] rd_data,
  output logic            fault_ud,
  output logic [XLEN-1:0] fs_base,
  output logic [XLEN-1:0] gs_base
);
  localparam int NUM_BASES = 2;

  sbu_op_e                  op;
  logic                     en_q;
  logic                     op_ok, op_ud, op_wr, op_idx;
  logic [XLEN-1:0]          wr_val, cur_base, rd_fmt;
  logic [NUM_BASES*XLEN-1:0] bases_flat;
  logic                     rd_valid_q, fault_q;
  logic [XLEN-1:0]          rd_data_q;

  assign op     = sbu_op_e'(op_code);
  assign op_wr  = sbu_is_write(op);
  assign op_idx = sbu_target(op);

  always_ff @(posedge clk) begin
    if (rst)        en_q <= 1'b0;
    else if (cr_we) en_q <= cr_en;
  end

  sbu_access_gate u_gate (
    .req  (op_valid),
    .en   (en_q),
    .mode (exec_mode),
    .grant(op_ok),
    .deny (op_ud)
  );

  sbu_width_fmt #(.XLEN(XLEN), .NARROW(NARROW)) u_wfmt (
    .din (op_src),
    .wide(op_wide),
    .dout(wr_val)
  );

  sbu_base_bank #(.XLEN(XLEN), .NUM_BASES(NUM_BASES)) u_bank (
    .clk       (clk),
    .rst       (rst),
    .ins_we    (op_ok && op_wr),
    .ins_idx   (op_idx),
    .ins_data  (wr_val),
    .ctx_we    (ctx_we),
    .ctx_idx   (ctx_sel),
    .ctx_data  (ctx_data),
    .bases_flat(bases_flat)
  );

  assign cur_base = op_idx ? bases_flat[XLEN +: XLEN] : bases_flat[0 +: XLEN];

  sbu_width_fmt #(.XLEN(XLEN), .NARROW(NARROW)) u_rfmt (
    .din (cur_base),
    .wide(op_wide),
    .dout(rd_fmt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid_q <= 1'b0;
      rd_data_q  <= '0;
      fault_q    <= 1'b0;
    end else begin
      rd_valid_q <= op_ok && !op_wr;
      fault_q    <= op_ud;
      if (op_ok && !op_wr) rd_data_q <= rd_fmt;
    end
  end

  assign rd_valid = rd_valid_q;
  assign rd_data  = rd_data_q;
  assign fault_ud = fault_q;
  assign fs_base  = bases_flat[0 +: XLEN];
  assign gs_base  = bases_flat[XLEN +: XLEN];
endmodule

// File: rtl/sbu_checker.sv
`timescale 1ns/1ps
module sbu_checker #(
  parameter int XLEN   = 64,
  parameter int NARROW = 32
) (
  input logic            clk,
  input logic            rst,
  input logic            op_valid,
  input logic [1:0]      op_code,
  input logic            op_wide,
  input logic [1:0]      exec_mode,
  input logic            ctx_we,
  input logic            ctx_sel,
  input logic [XLEN-1:0] ctx_data,
  input logic            en_q,
  input logic            rd_valid,
  input logic [XLEN-1:0] rd_data,
  input logic            fault_ud,
  input logic [XLEN-1:0] fs_base,
  input logic [XLEN-1:0] gs_base
);
  logic legal;
  assign legal = op_valid && en_q && (exec_mode == 2'b10);

  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (fs_base == '0 && gs_base == '0 && !rd_valid && !fault_ud && !en_q));

  assert_disabled_faults_R2: assert property (@(posedge clk) disable iff (rst)
    (op_valid && !en_q) |=> (fault_ud && !rd_valid));

  assert_mode_faults_R3: assert property (@(posedge clk) disable iff (rst)
    (op_valid && exec_mode != 2'b10) |=> (fault_ud && !rd_valid));

  assert_narrow_read_R5: assert property (@(posedge clk) disable iff (rst)
    (legal && !op_code[1] && !op_wide) |=> (rd_valid && rd_data[XLEN-1:NARROW] == '0));

  assert_narrow_write_R7: assert property (@(posedge clk) disable iff (rst)
    (legal && op_code == 2'b10 && !op_wide && !(ctx_we && !ctx_sel))
      |=> (fs_base[XLEN-1:NARROW] == '0));

  assert_fault_keeps_bases_R8: assert property (@(posedge clk) disable iff (rst)
    (fault_ud && !$past(ctx_we)) |-> ($stable(fs_base) && $stable(gs_base)));

  assert_fault_excl_R8: assert property (@(posedge clk) disable iff (rst)
    !(fault_ud && rd_valid));

  assert_ctx_fs_R9: assert property (@(posedge clk) disable iff (rst)
    (ctx_we && !ctx_sel) |=> (fs_base == $past(ctx_data)));

  assert_ctx_gs_R9: assert property (@(posedge clk) disable iff (rst)
    (ctx_we && ctx_sel) |=> (gs_base == $past(ctx_data)));
endmodule

bind seg_base_unit sbu_checker #(.XLEN(XLEN), .NARROW(NARROW)) u_chk (
  .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code),
  .op_wide(op_wide), .exec_mode(exec_mode), .ctx_we(ctx_we),
  .ctx_sel(ctx_sel), .ctx_data(ctx_data), .en_q(en_q),
  .rd_valid(rd_valid), .rd_data(rd_data), .fault_ud(fault_ud),
  .fs_base(fs_base), .gs_base(gs_base)
);

// File: tb/seg_base_unit_test.sv
`timescale 1ns/1ps
module seg_base_unit_test;
  localparam int XLEN = 64;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            op_valid = 1'b0;
  logic [1:0]      op_code = 2'b00;
  logic            op_wide = 1'b0;
  logic [XLEN-1:0] op_src = '0;
  logic [1:0]      exec_mode = 2'b10;
  logic            cr_we = 1'b0, cr_en = 1'b0;
  logic            ctx_we = 1'b0, ctx_sel = 1'b0;
  logic [XLEN-1:0] ctx_data = '0;
  logic            rd_valid, fault_ud;
  logic [XLEN-1:0] rd_data, fs_base, gs_base;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  seg_base_unit #(.XLEN(XLEN), .NARROW(32)) uut (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code),
    .op_wide(op_wide), .op_src(op_src), .exec_mode(exec_mode),
    .cr_we(cr_we), .cr_en(cr_en), .ctx_we(ctx_we), .ctx_sel(ctx_sel),
    .ctx_data(ctx_data), .rd_valid(rd_valid), .rd_data(rd_data),
    .fault_ud(fault_ud), .fs_base(fs_base), .gs_base(gs_base)
  );

  typedef struct packed {
    logic [1:0]  code;
    logic        wide;
    logic [1:0]  mode;
    logic [63:0] src;
    logic        efault;
    logic        erdv;
    logic [63:0] edata;
    logic [63:0] efs;
    logic [63:0] egs;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{2'b10, 1'b1, 2'b10, 64'h1122_3344_5566_7788, 1'b0, 1'b0, 64'h0, 64'h1122_3344_5566_7788, 64'h0},
    '{2'b00, 1'b1, 2'b10, 64'h0, 1'b0, 1'b1, 64'h1122_3344_5566_7788, 64'h1122_3344_5566_7788, 64'h0},
    '{2'b00, 1'b0, 2'b10, 64'h0, 1'b0, 1'b1, 64'h0000_0000_5566_7788, 64'h1122_3344_5566_7788, 64'h0},
    '{2'b11, 1'b0, 2'b10, 64'hDEAD_BEEF_CAFE_F00D, 1'b0, 1'b0, 64'h0, 64'h1122_3344_5566_7788, 64'h0000_0000_CAFE_F00D},
    '{2'b01, 1'b1, 2'b10, 64'h0, 1'b0, 1'b1, 64'h0000_0000_CAFE_F00D, 64'h1122_3344_5566_7788, 64'h0000_0000_CAFE_F00D},
    '{2'b11, 1'b1, 2'b10, 64'hFFFF_0000_1234_5678, 1'b0, 1'b0, 64'h0, 64'h1122_3344_5566_7788, 64'hFFFF_0000_1234_5678},
    '{2'b01, 1'b0, 2'b10, 64'h0, 1'b0, 1'b1, 64'h0000_0000_1234_5678, 64'h1122_3344_5566_7788, 64'hFFFF_0000_1234_5678},
    '{2'b10, 1'b1, 2'b01, 64'h0, 1'b1, 1'b0, 64'h0, 64'h1122_3344_5566_7788, 64'hFFFF_0000_1234_5678},
    '{2'b01, 1'b1, 2'b00, 64'h0, 1'b1, 1'b0, 64'h0, 64'h1122_3344_5566_7788, 64'hFFFF_0000_1234_5678},
    '{2'b10, 1'b0, 2'b10, 64'hAAAA_AAAA_0000_0001, 1'b0, 1'b0, 64'h0, 64'h0000_0000_0000_0001, 64'hFFFF_0000_1234_5678},
    '{2'b00, 1'b1, 2'b11, 64'h0, 1'b1, 1'b0, 64'h0, 64'h0000_0000_0000_0001, 64'hFFFF_0000_1234_5678}
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  task automatic run_op(input logic [1:0] code, input logic wide, input logic [1:0] mode,
                        input logic [63:0] src);
    @(negedge clk);
    op_valid = 1'b1; op_code = code; op_wide = wide; exec_mode = mode; op_src = src;
    @(negedge clk);
    op_valid = 1'b0;
  endtask

  task automatic set_en(input logic v);
    @(negedge clk);
    cr_we = 1'b1; cr_en = v;
    @(negedge clk);
    cr_we = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 fs_base", fs_base, 64'h0);
    chk("R1 gs_base", gs_base, 64'h0);
    chk("R1 rd_valid", {63'h0, rd_valid}, 64'h0);
    chk("R1 fault", {63'h0, fault_ud}, 64'h0);
    rst = 1'b0;

    // R2: disabled write faults and leaves FS untouched
    run_op(2'b10, 1'b1, 2'b10, 64'h5555_5555_5555_5555);
    chk("R2 fault", {63'h0, fault_ud}, 64'h1);
    chk("R2 rd_valid", {63'h0, rd_valid}, 64'h0);
    chk("R2 fs_base", fs_base, 64'h0);
    // R8: strobe lasts one cycle
    @(negedge clk);
    chk("R8 fault one cycle", {63'h0, fault_ud}, 64'h0);

    // R10: enable write in same cycle as request -> old value used
    @(negedge clk);
    cr_we = 1'b1; cr_en = 1'b1;
    op_valid = 1'b1; op_code = 2'b10; op_wide = 1'b1; exec_mode = 2'b10;
    op_src = 64'h0123_4567_89AB_CDEF;
    @(negedge clk);
    cr_we = 1'b0; op_valid = 1'b0;
    chk("R10 same-cycle fault", {63'h0, fault_ud}, 64'h1);
    chk("R10 same-cycle fs", fs_base, 64'h0);
    run_op(2'b10, 1'b1, 2'b10, 64'h0123_4567_89AB_CDEF);
    chk("R10 next-cycle no fault", {63'h0, fault_ud}, 64'h0);
    chk("R10 next-cycle fs", fs_base, 64'h0123_4567_89AB_CDEF);

    // Table walk: R3 R4 R5 R6 R7
    for (int i = 0; i < NV; i++) begin
      run_op(VECS[i].code, VECS[i].wide, VECS[i].mode, VECS[i].src);
      chk($sformatf("R3/R8 fault vec%0d", i), {63'h0, fault_ud}, {63'h0, VECS[i].efault});
      chk($sformatf("R4/R6 rd_valid vec%0d", i), {63'h0, rd_valid}, {63'h0, VECS[i].erdv});
      if (VECS[i].erdv)
        chk($sformatf("R4/R5 rd_data vec%0d", i), rd_data, VECS[i].edata);
      chk($sformatf("R6/R7 fs vec%0d", i), fs_base, VECS[i].efs);
      chk($sformatf("R6/R7 gs vec%0d", i), gs_base, VECS[i].egs);
    end

    // R9: context load beats same-base instruction write
    @(negedge clk);
    ctx_we = 1'b1; ctx_sel = 1'b0; ctx_data = 64'hC0DE_0000_0000_0001;
    op_valid = 1'b1; op_code = 2'b10; op_wide = 1'b1; exec_mode = 2'b10;
    op_src = 64'h9999_9999_9999_9999;
    @(negedge clk);
    ctx_we = 1'b0; op_valid = 1'b0;
    chk("R9 ctx wins fs", fs_base, 64'hC0DE_0000_0000_0001);
    // R9: different targets both apply
    @(negedge clk);
    ctx_we = 1'b1; ctx_sel = 1'b1; ctx_data = 64'h7777_0000_8888_0000;
    op_valid = 1'b1; op_code = 2'b10; op_wide = 1'b1; exec_mode = 2'b10;
    op_src = 64'h1234_0000_5678_0000;
    @(negedge clk);
    ctx_we = 1'b0; op_valid = 1'b0;
    chk("R9 ctx gs", gs_base, 64'h7777_0000_8888_0000);
    chk("R9 instr fs", fs_base, 64'h1234_0000_5678_0000);

    // R9: context load works while disabled; R2 read faults while disabled
    set_en(1'b0);
    run_op(2'b01, 1'b1, 2'b10, 64'h0);
    chk("R2 disabled read fault", {63'h0, fault_ud}, 64'h1);
    chk("R2 disabled read rd_valid", {63'h0, rd_valid}, 64'h0);
    @(negedge clk);
    ctx_we = 1'b1; ctx_sel = 1'b1; ctx_data = 64'hFEED_FACE_0BAD_F00D;
    @(negedge clk);
    ctx_we = 1'b0;
    chk("R9 ctx while disabled", gs_base, 64'hFEED_FACE_0BAD_F00D);

    finish_up();
  end
endmodule